// File: doc/BRIEF.md
# Mask-Decoded Memory-Mapped Bus Interconnect

This block connects a single memory-mapped bus master to a fixed group of slave ports. Each slave owns an address window, defined by a base value and a mask. A window matches when the master address, ANDed with the window's mask, equals the window's base. The master's request is captured on the falling clock edge. On the rising edge the block decodes the request and runs the slave handshake. The chosen slave gets its own read or write strobe and a word offset relative to its window. That offset is the address with the masked bits cleared, shifted right by two.

A transfer that the slave stalls locks the selection until that slave lowers its waitrequest. Some accesses are faulty: an unaligned address, an address that no window claims, or read and write asserted together. These are never forwarded. The block completes them at once, with readdata of zero, and raises a one-cycle error pulse, so the master cannot hang. The number of slaves and their windows are parameters. Elaboration checks that every base fits inside its own mask.

Top module: `memmap_xbar`

## Requirements
- R1: The master's request inputs are sampled on the falling clock edge. A change applied after a rising edge does not reach any slave strobe before the next falling edge.
- R2: A request reaches slave i when (address AND mask i) equals base i. Only that slave gets a read or write strobe, and at most one strobe bit in total is high.
- R3: When several windows match, the slave with the lowest index is chosen.
- R4: Each slave's offset port carries bits [31:2] of (address AND NOT its mask), which is a 32-bit word index inside its window.
- R5: Writedata and byteenable reach the slaves unchanged. The master's waitrequest and readdata come from the selected slave.
- R6: If the selected slave holds waitrequest high at a rising edge, the selection is locked and later address changes are ignored. The lock holds until a rising edge at which that slave's waitrequest is low. The next request is then decoded afresh.
- R7: A request whose address bits [1:0] are not 00 is not forwarded. It sees waitrequest low and readdata 0, and the unaligned flag is high for the cycle after the rising edge that evaluated it.
- R8: A request that matches no window is not forwarded. It completes with waitrequest low and readdata 0. The hole flag pulses, and the hole-write flag is 1 for a write and 0 for a read.
- R9: Read and write asserted together are not forwarded. They complete with waitrequest low and raise the protocol flag.
- R10: A synchronous active-high reset clears the selection lock, the captured request and all error flags.
- R11: Each error flag is a pulse. Once the faulty request is withdrawn, the flag is low after the following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; requests captured on the falling edge, decode on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| m_address_i | input | 32 | Master byte address |
| m_read_i | input | 1 | Master read request |
| m_write_i | input | 1 | Master write request |
| m_writedata_i | input | 32 | Master write data |
| m_byteenable_i | input | 4 | Master byte lanes |
| m_readdata_o | output | 32 | Read data returned to the master |
| m_waitrequest_o | output | 1 | Stall to the master |
| s_read_o | output | NUM_SLAVES | Per-slave read strobe |
| s_write_o | output | NUM_SLAVES | Per-slave write strobe |
| s_offset_o | output | NUM_SLAVES x 30 | Per-slave word offset within its window |
| s_writedata_o | output | 32 | Write data shared by all slaves |
| s_byteenable_o | output | 4 | Byte lanes shared by all slaves |
| s_readdata_i | input | NUM_SLAVES x 32 | Per-slave read data |
| s_waitrequest_i | input | NUM_SLAVES | Per-slave stall |
| err_unaligned_o | output | 1 | Unaligned access pulse |
| err_hole_o | output | 1 | Unmapped access pulse |
| err_hole_write_o | output | 1 | Unmapped access was a write |
| err_proto_o | output | 1 | Read and write together pulse |

## Verification
The bench changes a request two time units after a rising edge. The strobes, offsets, waitrequest and readdata depend on combinational paths from the falling-edge capture register, so they are due half a cycle later. The bench samples them one unit after the falling edge. It also probes once before that edge, to show that nothing leaked through early. The error flags and the lock come from registers updated at the rising edge that evaluates the captured request. The bench reads them two units after that edge, and reads them again one cycle after the request is withdrawn to confirm they are pulses.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int BE_W       = DATA_W / 8;
    localparam int OFF_W      = ADDR_W - 2;
    localparam int MAX_SLAVES = 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic [BE_W-1:0]   be;
    } req_t;

endpackage

// File: rtl/xbar_req_capture.sv
module xbar_req_capture
    import xbar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [BE_W-1:0]   be_i,
    output req_t              req_o
);

    req_t req_d, req_q;

    always_comb begin
        req_d.addr  = addr_i;
        req_d.rd    = rd_i;
        req_d.wr    = wr_i;
        req_d.wdata = wdata_i;
        req_d.be    = be_i;
        if (rst) begin
            req_d = '0;
        end
    end

    // Falling-edge register: the decode side sees a half-cycle-old request.
    always_ff @(negedge clk) begin
        req_q <= req_d;
    end

    assign req_o = req_q;

endmodule

// File: rtl/xbar_addr_decode.sv
module xbar_addr_decode
    import xbar_pkg::*;
#(
    parameter int NUM_SLAVES = 3,
    parameter int SEL_W      = 2,
    parameter logic [MAX_SLAVES-1:0][ADDR_W-1:0] SLAVE_BASE = '0,
    parameter logic [MAX_SLAVES-1:0][ADDR_W-1:0] SLAVE_MASK = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [SEL_W-1:0]  idx_o
);

    logic [NUM_SLAVES-1:0] match;

    for (genvar i = 0; i < NUM_SLAVES; i++) begin : g_win
        assign match[i] = (addr_i & SLAVE_MASK[i]) == SLAVE_BASE[i];

        initial begin
            assert_base_in_mask_R2: assert ((SLAVE_BASE[i] & SLAVE_MASK[i]) == SLAVE_BASE[i])
                else $error("window %0d: base has bits outside its mask", i);
        end
    end

    // Walk from the top so the lowest matching index is the last one written.
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_SLAVES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_o = 1'b1;
                idx_o = SEL_W'(i);
            end
        end
    end

endmodule

// File: rtl/memmap_xbar.sv
module memmap_xbar
    import xbar_pkg::*;
#(
    parameter int NUM_SLAVES = 3,
    parameter logic [MAX_SLAVES-1:0][ADDR_W-1:0] SLAVE_BASE = {
        32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
        32'h1000_0000, 32'h1000_0000, 32'h0000_0000},
    parameter logic [MAX_SLAVES-1:0][ADDR_W-1:0] SLAVE_MASK = {
        32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
        32'hF000_0000, 32'hFFFF_0000, 32'hF000_0000}
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [31:0]                          m_address_i,
    input  logic                                 m_read_i,
    input  logic                                 m_write_i,
    input  logic [31:0]                          m_writedata_i,
    input  logic [3:0]                           m_byteenable_i,
    output logic [31:0]                          m_readdata_o,
    output logic                                 m_waitrequest_o,
    output logic [NUM_SLAVES-1:0]                s_read_o,
    output logic [NUM_SLAVES-1:0]                s_write_o,
    output logic [NUM_SLAVES-1:0][29:0]          s_offset_o,
    output logic [31:0]                          s_writedata_o,
    output logic [3:0]                           s_byteenable_o,
    input  logic [NUM_SLAVES-1:0][31:0]          s_readdata_i,
    input  logic [NUM_SLAVES-1:0]                s_waitrequest_i,
    output logic                                 err_unaligned_o,
    output logic                                 err_hole_o,
    output logic                                 err_hole_write_o,
    output logic                                 err_proto_o
);

    localparam int SEL_W = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1;

    typedef struct packed {
        logic             busy;
        logic [SEL_W-1:0] sel;
        logic             unal;
        logic             hole;
        logic             hole_wr;
        logic             proto;
    } state_t;

    state_t st_d, st_q;
    req_t   req;

    logic             dec_hit;
    logic [SEL_W-1:0] dec_idx;
    logic             active, both, aligned, fwd_new, fwd;
    logic [SEL_W-1:0] sel_live;

    xbar_req_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .addr_i  (m_address_i),
        .rd_i    (m_read_i),
        .wr_i    (m_write_i),
        .wdata_i (m_writedata_i),
        .be_i    (m_byteenable_i),
        .req_o   (req)
    );

    xbar_addr_decode #(
        .NUM_SLAVES (NUM_SLAVES),
        .SEL_W      (SEL_W),
        .SLAVE_BASE (SLAVE_BASE),
        .SLAVE_MASK (SLAVE_MASK)
    ) u_decode (
        .addr_i (req.addr),
        .hit_o  (dec_hit),
        .idx_o  (dec_idx)
    );

    assign active   = req.rd | req.wr;
    assign both     = req.rd & req.wr;
    assign aligned  = (req.addr[1:0] == 2'b00);
    assign fwd_new  = !st_q.busy && active && !both && aligned && dec_hit;
    assign fwd      = st_q.busy || fwd_new;
    assign sel_live = st_q.busy ? st_q.sel : dec_idx;

    for (genvar i = 0; i < NUM_SLAVES; i++) begin : g_port
        logic [ADDR_W-1:0] local_addr;
        assign local_addr    = req.addr & ~SLAVE_MASK[i];
        assign s_offset_o[i] = local_addr[ADDR_W-1:2];
        assign s_read_o[i]   = fwd && (sel_live == SEL_W'(i)) && req.rd;
        assign s_write_o[i]  = fwd && (sel_live == SEL_W'(i)) && req.wr;
    end

    assign s_writedata_o   = req.wdata;
    assign s_byteenable_o  = req.be;
    assign m_waitrequest_o = fwd ? s_waitrequest_i[sel_live] : 1'b0;
    assign m_readdata_o    = fwd ? s_readdata_i[sel_live] : '0;

    always_comb begin
        st_d         = st_q;
        st_d.unal    = 1'b0;
        st_d.hole    = 1'b0;
        st_d.hole_wr = 1'b0;
        st_d.proto   = 1'b0;
        if (st_q.busy) begin
            if (!s_waitrequest_i[st_q.sel]) begin
                st_d.busy = 1'b0;
            end
        end else if (active) begin
            if (both) begin
                st_d.proto = 1'b1;
            end else if (!aligned) begin
                st_d.unal = 1'b1;
            end else if (!dec_hit) begin
                st_d.hole    = 1'b1;
                st_d.hole_wr = req.wr;
            end else if (s_waitrequest_i[dec_idx]) begin
                st_d.busy = 1'b1;
                st_d.sel  = dec_idx;
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign err_unaligned_o  = st_q.unal;
    assign err_hole_o       = st_q.hole;
    assign err_hole_write_o = st_q.hole_wr;
    assign err_proto_o      = st_q.proto;

    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(s_read_o | s_write_o));

    assert_lock_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && s_waitrequest_i[st_q.sel]) |=> (st_q.busy && st_q.sel == $past(st_q.sel)));

    assert_no_fwd_on_fault_R7: assert property (@(posedge clk) disable iff (rst)
        (active && !st_q.busy && (!aligned || both || !dec_hit))
            |-> ((s_read_o | s_write_o) == '0 && !m_waitrequest_o));

    assert_hole_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        err_hole_write_o |-> err_hole_o);

    assert_proto_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(err_proto_o) |-> $past(both && !st_q.busy));

endmodule

// File: tb/memmap_xbar_tb.sv
module memmap_xbar_tb;

    localparam int N = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [31:0]       m_address = '0;
    logic              m_read = 1'b0;
    logic              m_write = 1'b0;
    logic [31:0]       m_writedata = '0;
    logic [3:0]        m_byteenable = '0;
    logic [31:0]       m_readdata;
    logic              m_waitrequest;
    logic [N-1:0]      s_read, s_write;
    logic [N-1:0][29:0] s_offset;
    logic [31:0]       s_writedata;
    logic [3:0]        s_byteenable;
    logic [N-1:0][31:0] s_readdata;
    logic [N-1:0]      s_waitrequest = '0;
    logic              err_unal, err_hole, err_hole_wr, err_proto;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    assign s_readdata[0] = 32'hA0A0_0000;
    assign s_readdata[1] = 32'hA0A0_0001;
    assign s_readdata[2] = 32'hA0A0_0002;

    memmap_xbar u_dut (
        .clk              (clk),
        .rst              (rst),
        .m_address_i      (m_address),
        .m_read_i         (m_read),
        .m_write_i        (m_write),
        .m_writedata_i    (m_writedata),
        .m_byteenable_i   (m_byteenable),
        .m_readdata_o     (m_readdata),
        .m_waitrequest_o  (m_waitrequest),
        .s_read_o         (s_read),
        .s_write_o        (s_write),
        .s_offset_o       (s_offset),
        .s_writedata_o    (s_writedata),
        .s_byteenable_o   (s_byteenable),
        .s_readdata_i     (s_readdata),
        .s_waitrequest_i  (s_waitrequest),
        .err_unaligned_o  (err_unal),
        .err_hole_o       (err_hole),
        .err_hole_write_o (err_hole_wr),
        .err_proto_o      (err_proto)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        #2;
    endtask

    task automatic mid();
        @(negedge clk);
        #1;
    endtask

    task automatic put(input logic rd, input logic wr, input logic [31:0] a,
                       input logic [31:0] wd, input logic [3:0] be);
        m_read = rd; m_write = wr; m_address = a; m_writedata = wd; m_byteenable = be;
    endtask

    task automatic idle();
        put(1'b0, 1'b0, 32'h0, 32'h0, 4'h0);
    endtask

    task automatic flags_clear(input string tag);
        chk(tag, {28'h0, err_unal, err_hole, err_hole_wr, err_proto}, 32'h0);
    endtask

    task automatic t_reset_state();
        flags_clear("R10 flags after reset");
        chk("R10 no strobes after reset", {29'h0, s_read}, 32'h0);
    endtask

    task automatic t_capture_phase();
        cycle();
        put(1'b1, 1'b0, 32'h0000_1008, 32'h0, 4'hF);
        #1;
        chk("R1 no strobe before falling edge", {29'h0, s_read}, 32'h0);
        mid();
        chk("R1 strobe after falling edge", {29'h0, s_read}, 32'h1);
        chk("R2 slave0 read strobe", {29'h0, s_read}, 32'h1);
        chk("R4 slave0 offset", {2'b0, s_offset[0]}, 32'h402);
        chk("R5 readdata from slave0", m_readdata, 32'hA0A0_0000);
        chk("R5 waitrequest from slave0", {31'h0, m_waitrequest}, 32'h0);
        cycle();
        idle();
        mid();
        cycle();
    endtask

    task automatic t_priority();
        put(1'b1, 1'b0, 32'h1000_0010, 32'h0, 4'hF);
        mid();
        chk("R3 lowest index wins on overlap", {29'h0, s_read}, 32'h2);
        chk("R4 slave1 offset", {2'b0, s_offset[1]}, 32'h4);
        chk("R5 readdata from slave1", m_readdata, 32'hA0A0_0001);
        cycle();
        put(1'b1, 1'b0, 32'h1001_0000, 32'h0, 4'hF);
        mid();
        chk("R2 only slave2 window matches", {29'h0, s_read}, 32'h4);
        chk("R4 slave2 offset", {2'b0, s_offset[2]}, 32'h4000);
        cycle();
        idle();
        mid();
        cycle();
    endtask

    task automatic t_write_pass();
        put(1'b0, 1'b1, 32'h1000_0104, 32'hDEAD_BEEF, 4'b0110);
        mid();
        chk("R2 slave1 write strobe", {29'h0, s_write}, 32'h2);
        chk("R2 no read strobe on write", {29'h0, s_read}, 32'h0);
        chk("R5 writedata passes", s_writedata, 32'hDEAD_BEEF);
        chk("R5 byteenable passes", {28'h0, s_byteenable}, 32'h6);
        chk("R4 write offset", {2'b0, s_offset[1]}, 32'h41);
        cycle();
        idle();
        mid();
        cycle();
    endtask

    task automatic t_lock();
        s_waitrequest = 3'b010;
        put(1'b1, 1'b0, 32'h1000_0010, 32'h0, 4'hF);
        mid();
        chk("R5 stall passes to master", {31'h0, m_waitrequest}, 32'h1);
        cycle();
        put(1'b1, 1'b0, 32'h0000_0020, 32'h0, 4'hF);
        mid();
        chk("R6 locked selection ignores new address", {29'h0, s_read}, 32'h2);
        chk("R6 still stalled", {31'h0, m_waitrequest}, 32'h1);
        s_waitrequest = 3'b000;
        #1;
        chk("R6 release visible to master", {31'h0, m_waitrequest}, 32'h0);
        cycle();
        mid();
        chk("R6 redecode after release", {29'h0, s_read}, 32'h1);
        cycle();
        idle();
        mid();
        cycle();
    endtask

    task automatic t_unaligned();
        put(1'b1, 1'b0, 32'h0000_0002, 32'h0, 4'hF);
        mid();
        chk("R7 unaligned not forwarded", {29'h0, s_read}, 32'h0);
        chk("R7 unaligned completes", {31'h0, m_waitrequest}, 32'h0);
        chk("R7 unaligned readdata zero", m_readdata, 32'h0);
        cycle();
        chk("R7 unaligned flag", {28'h0, err_unal, err_hole, err_hole_wr, err_proto}, 32'h8);
        idle();
        mid();
        cycle();
        flags_clear("R11 unaligned flag is a pulse");
    endtask

    task automatic t_hole(input logic wr);
        put(~wr, wr, 32'h2000_0000, 32'h1234_5678, 4'hF);
        mid();
        chk("R8 hole not forwarded", {26'h0, s_read, s_write}, 32'h0);
        chk("R8 hole completes", {31'h0, m_waitrequest}, 32'h0);
        chk("R8 hole readdata zero", m_readdata, 32'h0);
        cycle();
        chk(wr ? "R8 hole write flags" : "R8 hole read flags",
            {28'h0, err_unal, err_hole, err_hole_wr, err_proto}, wr ? 32'h6 : 32'h4);
        idle();
        mid();
        cycle();
        flags_clear("R11 hole flags are pulses");
    endtask

    task automatic t_proto();
        put(1'b1, 1'b1, 32'h0000_0000, 32'h0, 4'hF);
        mid();
        chk("R9 both not forwarded", {26'h0, s_read, s_write}, 32'h0);
        chk("R9 both completes", {31'h0, m_waitrequest}, 32'h0);
        cycle();
        chk("R9 protocol flag", {28'h0, err_unal, err_hole, err_hole_wr, err_proto}, 32'h1);
        idle();
        mid();
        cycle();
        flags_clear("R11 protocol flag is a pulse");
    endtask

    task automatic t_reset_lock();
        s_waitrequest = 3'b010;
        put(1'b1, 1'b0, 32'h1000_0000, 32'h0, 4'hF);
        mid();
        cycle();
        rst = 1'b1;
        idle();
        mid();
        cycle();
        rst = 1'b0;
        put(1'b1, 1'b0, 32'h0000_0040, 32'h0, 4'hF);
        mid();
        chk("R10 reset drops lock", {29'h0, s_read}, 32'h1);
        chk("R10 new target not stalled", {31'h0, m_waitrequest}, 32'h0);
        s_waitrequest = 3'b000;
        cycle();
        idle();
        mid();
        cycle();
    endtask

    initial begin
        rst = 1'b1;
        cycle();
        cycle();
        rst = 1'b0;
        mid();
        t_reset_state();
        t_capture_phase();
        t_priority();
        t_write_pass();
        t_lock();
        t_unaligned();
        t_hole(1'b0);
        t_hole(1'b1);
        t_proto();
        t_reset_lock();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule